// File: doc/BRIEF.md
# Serial Memory Write Guard

This block sits between the command decoder of an 8192-byte serial nonvolatile memory and its programming engine. For every write request it decides whether the programming may go ahead. A request carries a start address, a byte count for a page of up to 32 bytes, and a data byte. The block answers one cycle later with either a grant strobe or a reject flag. The byte at the very top of the address space is not array storage. It is a protection register, and a single-byte write to that address changes the register instead of the array.

Three rules combine to protect the memory:
- A volatile enable latch must be set before any array byte can be programmed.
- A two-bit region field locks none, the top quarter, the top half, or all of the array.
- A stored arming bit, together with a high level on the protect pin, freezes the protection register itself.

The arming bit and the region field survive a reset. The enable latch does not. The register is always visible on a read-back bus.

Top module: `wguard_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `wrAllow` and `wrReject` are low and the enable latch, `regValue[0]`, is 0.
- R2: A request that is not a protection-register write is rejected while the enable latch is 0.
- R3: The region field `regValue[3:2]` blocks array writes by address. Value 00 blocks nothing, 01 blocks 1800h–1FFFh, 10 blocks 1000h–1FFFh and 11 blocks every address. With the latch set, a write outside the blocked region is granted.
- R4: A page covers the byte addresses start+0 … start+`reqLen`, and the offset wraps inside its aligned 32-byte page. The page is granted only if every covered byte passes. A page of more than one byte that covers 1FFFh is rejected.
- R5: A request with `reqAddr`=1FFFh and `reqLen`=0 is a register write. When the register is not locked, it is granted and `reqData[0]` becomes the enable latch.
- R6: In a granted register write, `reqData[3:2]` (region) and `reqData[7]` (arming bit) are taken only if the enable latch was already 1 before the write. Otherwise those bits keep their old value.
- R7: While the arming bit is 1 and `wpPin` is high, a register write is rejected and the register does not change. Array writes are still judged by R2–R4 alone.
- R8: While the arming bit is 0, a high `wpPin` has no effect: register writes are granted, and the lock of R7 begins only once the arming bit is 1.
- R9: Reset clears the enable latch and leaves the region field and the arming bit unchanged.
- R10: `regValue` reads {arming bit, 3'b000, region[1:0], 1'b0, enable latch}. A register update is visible there in the cycle after the request.
- R11: Each request cycle produces exactly one of `wrAllow` or `wrReject`, high for exactly the following cycle. Without a request, both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle write request |
| reqAddr | input | 13 | Start byte address of the page |
| reqLen | input | 5 | Page byte count minus one |
| reqData | input | 8 | Data byte (used for register writes) |
| wpPin | input | 1 | Hardware protect pin level |
| wrAllow | output | 1 | Write granted, one cycle after the request |
| wrReject | output | 1 | Write refused, one cycle after the request |
| regValue | output | 8 | Protection register read-back |

## Verification
Every result of this block is due exactly one clock edge after the request cycle: the grant or reject strobe and the updated `regValue` all appear together. The driver task applies each request on a falling edge and pushes the expected strobe pair and register value into a queue. The monitor samples 1 ns after the next rising edge and pops one item per request, so no check looks a cycle early or late. Cycles without a request must show both strobes low. Reset persistence is read directly on `regValue` in the first cycle after reset is released.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

  localparam int DATA_W = 8;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic grant;   // request accepted
    logic reject;  // request refused
    logic regWr;   // accepted write to the protection register
    logic cfgWr;   // region and arming bits may take the new data
  } ctrlStrb_t;

  // status the datapath reports to the control module
  typedef struct packed {
    logic isRegAcc;   // single-byte write at the top address
    logic touchesReg; // some covered byte is the top address
    logic anyProt;    // some covered byte lies in the locked region
    logic wel;        // enable latch
    logic hwLock;     // arming bit and pin both high
  } dpStat_t;

endpackage

// File: rtl/wguard_dp.sv
module wguard_dp
  import wguard_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PAGE_W-1:0] reqLen,
  input  logic [DATA_W-1:0] reqData,
  input  logic              wpPin,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  output logic [DATA_W-1:0] regValue
);

  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  logic       welQ;
  logic [1:0] bpQ;
  logic       wpenQ;

  logic [PAGE_SZ-1:0] protVec;
  logic [PAGE_SZ-1:0] regVec;
  logic               unusedData;

  assign unusedData = ^{reqData[6:4], reqData[1]};

  // enable latch: volatile, cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           welQ <= 1'b0;
    else if (strb.regWr) welQ <= reqData[0];
  end

  // region and arming bits: kept across reset
  always_ff @(posedge clk) begin
    if (strb.cfgWr) begin
      bpQ   <= reqData[3:2];
      wpenQ <= reqData[7];
    end
  end

  // check every byte of the page, offset wrapping inside the page
  for (genvar i = 0; i < PAGE_SZ; i++) begin : g_byte
    localparam logic [PAGE_W-1:0] OFS = PAGE_W'(i);
    logic [PAGE_W-1:0] offI;
    logic [ADDR_W-1:0] addrI;
    logic              inPage;
    logic [1:0]        topBits;
    logic              lockedI;

    assign offI    = reqAddr[PAGE_W-1:0] + OFS;
    assign addrI   = {reqAddr[ADDR_W-1:PAGE_W], offI};
    assign inPage  = (OFS <= reqLen);
    assign topBits = addrI[ADDR_W-1 -: 2];

    always_comb begin
      unique case (bpQ)
        2'b00:   lockedI = 1'b0;
        2'b01:   lockedI = (topBits == 2'b11);
        2'b10:   lockedI = topBits[1];
        default: lockedI = 1'b1;
      endcase
    end

    assign protVec[i] = inPage && lockedI;
    assign regVec[i]  = inPage && (addrI == REG_ADDR);
  end

  assign stat.isRegAcc   = (reqAddr == REG_ADDR) && (reqLen == '0);
  assign stat.touchesReg = |regVec;
  assign stat.anyProt    = |protVec;
  assign stat.wel        = welQ;
  assign stat.hwLock     = wpenQ && wpPin;

  assign regValue = {wpenQ, 3'b000, bpQ, 1'b0, welQ};

  // R7: the control module never writes the register while it is locked
  assert_locked_reg_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWr |-> !stat.hwLock);

  // R6: region or arming bits change only when the latch was set before
  assert_cfg_needs_wel_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({wpenQ, bpQ}) |-> $past(welQ));

  // R1: reset leaves the latch clear
  assert_wel_reset_R1: assert property (@(posedge clk)
    !rstN |=> !welQ);

endmodule

// File: rtl/wguard_ctrl.sv
module wguard_ctrl
  import wguard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      wrAllow,
  output logic      wrReject
);

  logic arrayOk;
  logic regOk;
  logic reqOk;

  assign arrayOk = stat.wel && !stat.anyProt && !stat.touchesReg;
  assign regOk   = !stat.hwLock;
  assign reqOk   = stat.isRegAcc ? regOk : arrayOk;

  always_comb begin
    strb.grant  = reqValid && reqOk;
    strb.reject = reqValid && !reqOk;
    strb.regWr  = strb.grant && stat.isRegAcc;
    strb.cfgWr  = strb.regWr && stat.wel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAllow  <= 1'b0;
      wrReject <= 1'b0;
    end else begin
      wrAllow  <= strb.grant;
      wrReject <= strb.reject;
    end
  end

  // R11: never both outputs at once
  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrAllow, wrReject}));

  // R11: every request gets exactly one answer in the next cycle
  assert_req_answered_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (wrAllow ^ wrReject));

  // R11: no answer without a request
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(wrAllow || wrReject));

  // R2: array writes need the enable latch
  assert_array_needs_wel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !stat.isRegAcc && !stat.wel) |=> wrReject);

  // R4: a multi-byte page covering the register address is refused
  assert_reg_not_in_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && stat.touchesReg && !stat.isRegAcc) |=> !wrAllow);

endmodule

// File: rtl/wguard_top.sv
module wguard_top
  import wguard_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PAGE_W-1:0] reqLen,
  input  logic [DATA_W-1:0] reqData,
  input  logic              wpPin,
  output logic              wrAllow,
  output logic              wrReject,
  output logic [DATA_W-1:0] regValue
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  wguard_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .stat     (stat),
    .strb     (strb),
    .wrAllow  (wrAllow),
    .wrReject (wrReject)
  );

  wguard_dp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqData  (reqData),
    .wpPin    (wpPin),
    .strb     (strb),
    .stat     (stat),
    .regValue (regValue)
  );

endmodule

// File: tb/wguard_top_tb_top.sv
module wguard_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [4:0]  reqLen = '0;
  logic [7:0]  reqData = '0;
  logic        wpPin = 1'b0;
  logic        wrAllow;
  logic        wrReject;
  logic [7:0]  regValue;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic       allow;
    logic       rej;
    logic [7:0] rv;
    logic [7:0] mask;
    string      tag;
  } expItem_t;

  expItem_t q[$];

  // bench model of the register
  logic       mWel = 1'b0;
  logic [1:0] mBp = 2'b00;
  logic       mWpen = 1'b0;
  bit         known = 0;

  always #2 clk = ~clk;

  wguard_top dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqData  (reqData),
    .wpPin    (wpPin),
    .wrAllow  (wrAllow),
    .wrReject (wrReject),
    .regValue (regValue)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit inRegion(input logic [12:0] a, input logic [1:0] bp);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a[12:11] == 2'b11;
      2'b10:   return a[12];
      default: return 1'b1;
    endcase
  endfunction

  // driver: computes the expected answer, pushes it, drives one cycle
  task automatic doReq(input logic [12:0] a, input logic [4:0] n, input logic [7:0] d,
                       input logic wp, input string tag);
    expItem_t e;
    bit isReg, touch, prot, ok;
    isReg = (a == 13'h1FFF) && (n == 0);
    if (isReg) begin
      ok = !(mWpen && wp);
      if (ok) begin
        if (mWel) begin
          mBp = d[3:2];
          mWpen = d[7];
          known = 1;
        end
        mWel = d[0];
      end
    end else begin
      touch = 0;
      prot = 0;
      for (int i = 0; i < 32; i++) begin
        logic [12:0] ai;
        if (i <= int'(n)) begin
          ai = {a[12:5], 5'(a[4:0] + 5'(i))};
          if (ai == 13'h1FFF) touch = 1;
          if (inRegion(ai, mBp)) prot = 1;
        end
      end
      ok = mWel && !touch && !prot;
    end
    e.allow = ok;
    e.rej = !ok;
    e.rv = {mWpen, 3'b000, mBp, 1'b0, mWel};
    e.mask = known ? 8'hFF : 8'h01;
    e.tag = tag;
    q.push_back(e);
    reqValid = 1'b1;
    reqAddr = a;
    reqLen = n;
    reqData = d;
    wpPin = wp;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: one expected item per request, idle check otherwise
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      chk(wrAllow == e.allow && wrReject == e.rej, {e.tag, " strobes"},
          {14'd0, wrAllow, wrReject}, {14'd0, e.allow, e.rej});
      chk((regValue & e.mask) == (e.rv & e.mask), {e.tag, " R10 regValue"},
          {8'd0, regValue & e.mask}, {8'd0, e.rv & e.mask});
    end else if (rstN) begin
      chk(!wrAllow && !wrReject, "R11 idle strobes", {14'd0, wrAllow, wrReject}, 16'd0);
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    mWel = 1'b0;
    @(negedge clk);
    chk(!wrAllow && !wrReject && regValue[0] == 1'b0, "R1 in reset",
        {7'd0, wrAllow, wrReject, regValue[0]}, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!wrAllow && !wrReject && regValue[0] == 1'b0, "R1 after reset",
        {7'd0, wrAllow, wrReject, regValue[0]}, 16'd0);

    doReq(13'h0000, 5'd0, 8'hAA, 1'b0, "R2 single byte latch clear");
    doReq(13'h0ABC, 5'd3, 8'h55, 1'b0, "R2 page latch clear");
    doReq(13'h1FFF, 5'd0, 8'h01, 1'b0, "R5 set latch");
    doReq(13'h1FFF, 5'd0, 8'h00, 1'b0, "R6 clear config");
    doReq(13'h1FFF, 5'd0, 8'h8D, 1'b0, "R6 config ignored latch clear");
    doReq(13'h0000, 5'd31, 8'h11, 1'b0, "R3 region 00 low page");
    doReq(13'h1FE0, 5'd0, 8'h11, 1'b0, "R3 region 00 top page");
    doReq(13'h1FFF, 5'd0, 8'h05, 1'b0, "R6 region 01");
    doReq(13'h17FF, 5'd0, 8'h11, 1'b0, "R3 region 01 below");
    doReq(13'h1800, 5'd0, 8'h11, 1'b0, "R3 region 01 edge");
    doReq(13'h1FE0, 5'd30, 8'h11, 1'b0, "R3 region 01 page");
    doReq(13'h1FFF, 5'd0, 8'h09, 1'b0, "R6 region 10");
    doReq(13'h0FFF, 5'd0, 8'h11, 1'b0, "R3 region 10 below");
    doReq(13'h1000, 5'd0, 8'h11, 1'b0, "R3 region 10 edge");
    doReq(13'h0FFC, 5'd5, 8'h11, 1'b0, "R4 wrap inside page");
    doReq(13'h1FFF, 5'd0, 8'h0D, 1'b0, "R6 region 11");
    doReq(13'h0000, 5'd0, 8'h11, 1'b0, "R3 region 11 bottom");
    doReq(13'h1FFF, 5'd0, 8'h01, 1'b0, "R6 region back to 00");
    doReq(13'h1FE0, 5'd31, 8'h11, 1'b0, "R4 full page covers register");
    doReq(13'h1FF8, 5'd10, 8'h11, 1'b0, "R4 wrapped page covers register");
    doReq(13'h1FC0, 5'd31, 8'h11, 1'b0, "R4 page below register");
    @(negedge clk);
    doReq(13'h1FFF, 5'd0, 8'h05, 1'b1, "R8 pin high unarmed");
    doReq(13'h1FFF, 5'd0, 8'h85, 1'b1, "R8 arming with pin high");
    doReq(13'h1FFF, 5'd0, 8'h01, 1'b1, "R7 locked register");
    doReq(13'h1FFF, 5'd0, 8'h00, 1'b1, "R7 locked latch clear");
    doReq(13'h0000, 5'd7, 8'h11, 1'b1, "R7 array outside region");
    doReq(13'h1800, 5'd0, 8'h11, 1'b1, "R7 array inside region");
    doReq(13'h1FFF, 5'd0, 8'h85, 1'b0, "R7 pin low unlocks");
    @(negedge clk);
    doReset();
    chk(regValue == 8'h84, "R9 config survives reset", {8'd0, regValue}, 16'h0084);
    doReq(13'h1FFF, 5'd0, 8'h01, 1'b1, "R7 locked after reset");
    doReq(13'h0000, 5'd0, 8'h11, 1'b0, "R2 latch cleared by reset");
    doReq(13'h1FFF, 5'd0, 8'h01, 1'b0, "R5 set latch again");
    doReq(13'h1FFF, 5'd0, 8'h00, 1'b0, "R6 disarm");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11 all results seen", 16'(q.size()), 16'd0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule